// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives a serial clock for an SPI transfer engine from its own parent clock. A single 32-bit configuration word carries two 6-bit counts that matter. The divider count `n` sets the SCK period to `n+1` parent cycles. The high count `h` sets how many of those cycles SCK spends high, starting from the beginning of each period. Because the period and the high phase are programmed separately, any duty split that fits in the period can be produced, not only power-of-two divisions. A third 6-bit count is present in the word and is normally written equal to the divider. The default build ignores it, and a build-time option makes it the period source instead.

Alongside SCK the block issues two single-cycle strobes for the transfer engine. The sample strobe marks the rising SCK transition and the shift strobe marks the falling one. The engine uses these to capture input and to change output without watching SCK itself. While enable is low, SCK idles low and both strobes stay quiet. Each time enable rises, the clock pattern restarts from the start of a period. A configuration word that changes while the clock runs is picked up only at the next period boundary, so a period is never cut short or stretched.

Top module: `spi_sck_gen`

## Requirements
- R1: With divider count n = cfg[17:12] (1..63) and high count h = cfg[11:6] with h < n, SCK repeats with a period of n+1 parent cycles and is high for the first h+1 cycles of each period, then low for the remaining n-h cycles.
- R2: A divider count of 0 acts as 1, giving the fastest clock: a period of two parent cycles.
- R3: A high count of n or more acts as n-1, so every period keeps at least one low cycle.
- R4: SCK is low, and neither strobe fires, from the second rising parent-clock edge at which enable is sampled low. When enable is sampled high after being low, SCK goes high at the following edge and a fresh period begins. A fall of SCK caused by disabling raises no shift strobe.
- R5: sample_tick is high for exactly the one cycle in which SCK is first high after being low. shift_tick is high for exactly the one cycle in which SCK is first low after being high while running. The two are never high together.
- R6: A configuration change while running takes effect only at the start of the next period. The current period finishes with the counts that were in force when it began.
- R7: In the default build, configuration bits outside cfg[17:6] have no effect on any output. These include the third count at cfg[5:0] and the source-select bit at cfg[31].
- R8: While reset is asserted, SCK, sample_tick and shift_tick are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; low forces SCK idle |
| clk_cfg_i | input | 32 | Clock configuration word (divider 17:12, high count 11:6) |
| sck_o | output | 1 | Serial clock |
| sample_tick_o | output | 1 | One-cycle strobe on the rising SCK transition |
| shift_tick_o | output | 1 | One-cycle strobe on the falling SCK transition |

## Verification
The bench sweeps every divider from 1 to 16 against every legal high count and checks each cycle against an arithmetic model. It then covers the 63 extremes, the zero-divider and oversized-high-count clamps, and words with all unused bits set. Each case targets a specific failure. An off-by-one in the terminal compare would stretch or shrink every period. A missing clamp would either stall SCK at zero or leave it high with no falling edge. A decoder that reads the third count or the source bit would change the period when those bits are set. The bench also changes the configuration in the middle of a period and exactly on a wrap. A design that applies the new counts early would produce a truncated period at that point. It also drops enable in the high phase and in the low phase. A design that does not restart the counter on re-enable would resume mid-period, and one that flags the forced fall would emit a stray shift strobe.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

   // Which configuration field closes the SCK period
   typedef enum logic {
      TERM_DIVIDER  = 1'b0,
      TERM_LOWCOUNT = 1'b1
   } term_src_e;

   localparam int unsigned CFG_W_DEF   = 32;
   localparam int unsigned CNT_W_DEF   = 6;
   localparam int unsigned DIV_LSB_DEF = 12;
   localparam int unsigned HI_LSB_DEF  = 6;
   localparam int unsigned LO_LSB_DEF  = 0;

endpackage

// File: rtl/sck_cfg_decode.sv
module sck_cfg_decode #(
   parameter int unsigned           CFG_W    = sckgen_pkg::CFG_W_DEF,
   parameter int unsigned           CNT_W    = sckgen_pkg::CNT_W_DEF,
   parameter int unsigned           DIV_LSB  = sckgen_pkg::DIV_LSB_DEF,
   parameter int unsigned           HI_LSB   = sckgen_pkg::HI_LSB_DEF,
   parameter int unsigned           LO_LSB   = sckgen_pkg::LO_LSB_DEF,
   parameter sckgen_pkg::term_src_e TERM_SRC = sckgen_pkg::TERM_DIVIDER
) (
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CNT_W-1:0] term_o,
   output logic [CNT_W-1:0] hi_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] raw_div;
   logic [CNT_W-1:0] raw_hi;
   logic [CNT_W-1:0] raw_lo;
   logic [CNT_W-1:0] raw_term;
   logic             cfg_unused;

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (DIV_LSB + CNT_W <= CFG_W) else $error("divider field outside word");
      assert (HI_LSB + CNT_W <= CFG_W) else $error("high field outside word");
      assert (LO_LSB + CNT_W <= CFG_W) else $error("low field outside word");
   end

   assign raw_div    = cfg_i[DIV_LSB +: CNT_W];
   assign raw_hi     = cfg_i[HI_LSB +: CNT_W];
   assign raw_lo     = cfg_i[LO_LSB +: CNT_W];
   assign cfg_unused = ^cfg_i;

   // Build option: which field gives the terminal count
   generate
      if (TERM_SRC == sckgen_pkg::TERM_LOWCOUNT) begin : g_term_low
         assign raw_term = raw_lo;
      end else begin : g_term_div
         logic lo_unused;
         assign lo_unused = ^raw_lo;
         assign raw_term  = raw_div;
      end
   endgenerate

   // R2: zero divider behaves as one; R3: high count kept below terminal
   always_comb begin
      term_o = (raw_term == '0) ? ONE : raw_term;
      hi_o   = (raw_hi >= term_o) ? (term_o - ONE) : raw_hi;
   end

endmodule

// File: rtl/sck_phase_counter.sv
module sck_phase_counter #(
   parameter int unsigned CNT_W = sckgen_pkg::CNT_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] term_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] hi_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] hi_q;
   logic             wrap;

   assign wrap = (cnt_q == term_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         term_q <= ONE;
         hi_q   <= '0;
      end else if (!en_i || !run_q) begin
         // idle or first enabled edge: restart and take fresh counts
         run_q  <= en_i;
         cnt_q  <= '0;
         term_q <= term_i;
         hi_q   <= hi_i;
      end else if (wrap) begin
         cnt_q  <= '0;
         term_q <= term_i;
         hi_q   <= hi_i;
      end else begin
         cnt_q  <= cnt_q + ONE;
      end
   end

   assign run_o = run_q;
   assign cnt_o = cnt_q;
   assign hi_o  = hi_q;

   assert_cnt_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= term_q);

   assert_hi_below_term_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_q < term_q);

   assert_idle_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!run_q && cnt_q == '0));

   assert_counts_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && en_i && !wrap) |=> ($stable(term_q) && $stable(hi_q)));

endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen #(
   parameter int unsigned CNT_W = sckgen_pkg::CNT_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic             sck_o,
   output logic             sample_o,
   output logic             shift_o
);
   logic level;
   logic sck_q;
   logic sample_q;
   logic shift_q;

   assign level = run_i && (cnt_i <= hi_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_q    <= 1'b0;
         sample_q <= 1'b0;
         shift_q  <= 1'b0;
      end else begin
         sck_q    <= level;
         sample_q <= level & ~sck_q;
         shift_q  <= ~level & sck_q & run_i;
      end
   end

   assign sck_o    = sck_q;
   assign sample_o = sample_q;
   assign shift_o  = shift_q;

   assert_ticks_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sample_q && shift_q));

   assert_sample_on_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_q |-> sck_q);

   assert_shift_on_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_q |-> !sck_q);

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int unsigned           CFG_W    = sckgen_pkg::CFG_W_DEF,
   parameter int unsigned           CNT_W    = sckgen_pkg::CNT_W_DEF,
   parameter int unsigned           DIV_LSB  = sckgen_pkg::DIV_LSB_DEF,
   parameter int unsigned           HI_LSB   = sckgen_pkg::HI_LSB_DEF,
   parameter int unsigned           LO_LSB   = sckgen_pkg::LO_LSB_DEF,
   parameter sckgen_pkg::term_src_e TERM_SRC = sckgen_pkg::TERM_DIVIDER
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic [CFG_W-1:0] clk_cfg_i,
   output logic             sck_o,
   output logic             sample_tick_o,
   output logic             shift_tick_o
);
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] hi;
   logic             run;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_hi;

   sck_cfg_decode #(
      .CFG_W   (CFG_W),
      .CNT_W   (CNT_W),
      .DIV_LSB (DIV_LSB),
      .HI_LSB  (HI_LSB),
      .LO_LSB  (LO_LSB),
      .TERM_SRC(TERM_SRC)
   ) u_decode (
      .cfg_i (clk_cfg_i),
      .term_o(term),
      .hi_o  (hi)
   );

   sck_phase_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (enable_i),
      .term_i(term),
      .hi_i  (hi),
      .run_o (run),
      .cnt_o (cnt),
      .hi_o  (act_hi)
   );

   sck_edge_gen #(
      .CNT_W(CNT_W)
   ) u_edges (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .cnt_i   (cnt),
      .hi_i    (act_hi),
      .sck_o   (sck_o),
      .sample_o(sample_tick_o),
      .shift_o (shift_tick_o)
   );

   assert_term_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term != '0);

   assert_quiet_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> (!sck_o && !shift_tick_o && !sample_tick_o));

endmodule

// File: tb/sim_spi_sck_gen.sv
module sim_spi_sck_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [31:0] cfg = '0;
   logic        sck, smp, sft;

   int    checks = 0;
   int    errors = 0;
   string req = "R8";

   // reference state, derived from the requirements
   bit m_run = 0;
   int m_cnt = 0, m_term = 1, m_hi = 0;
   bit e_sck = 0, e_smp = 0, e_sft = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sck_gen u0 (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .enable_i     (en),
      .clk_cfg_i    (cfg),
      .sck_o        (sck),
      .sample_tick_o(smp),
      .shift_tick_o (sft)
   );

   function automatic void counts(input logic [31:0] c, output int t, output int h);
      t = int'(c[17:12]);
      if (t == 0) t = 1;            // R2
      h = int'(c[11:6]);
      if (h >= t) h = t - 1;        // R3
   endfunction

   function automatic void chk(input string r, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
      end
   endfunction

   // one parent cycle: advance the reference, clock, compare at negedge
   task automatic step();
      bit lvl, n_smp, n_sft;
      lvl   = m_run && (m_cnt <= m_hi);
      n_smp = lvl && !e_sck;
      n_sft = !lvl && e_sck && m_run;
      if (!en) begin
         m_run = 0; m_cnt = 0; counts(cfg, m_term, m_hi);
      end else if (!m_run) begin
         m_run = 1; m_cnt = 0; counts(cfg, m_term, m_hi);
      end else if (m_cnt == m_term) begin
         m_cnt = 0; counts(cfg, m_term, m_hi);
      end else begin
         m_cnt++;
      end
      e_sck = lvl; e_smp = n_smp; e_sft = n_sft;
      @(posedge clk);
      @(negedge clk);
      chk(req, "sck", int'(sck), int'(e_sck));
      chk(req, "sample_tick", int'(smp), int'(e_smp));
      chk(req, "shift_tick", int'(sft), int'(e_sft));
      chk("R5", "tick overlap", int'(smp && sft), 0);
   endtask

   task automatic run_cfg(input logic [31:0] c, input int cycles);
      cfg = c;
      en  = 1'b1;
      repeat (cycles) step();
      en  = 1'b0;
      repeat (3) step();
   endtask

   function automatic logic [31:0] mk(input int n, input int h, input int lo);
      return {14'b0, n[5:0], h[5:0], lo[5:0]};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      req = "R8";
      chk(req, "sck in reset", int'(sck), 0);
      chk(req, "sample in reset", int'(smp), 0);
      chk(req, "shift in reset", int'(sft), 0);
      rst_n = 1'b1;
      repeat (2) step();

      // R1: near-exhaustive sweep of small dividers
      req = "R1";
      for (int n = 1; n <= 16; n++)
         for (int h = 0; h < n; h++)
            run_cfg(mk(n, h, n), 3 * (n + 1) + 2);

      // R1: widest field values
      run_cfg(mk(63, 31, 63), 130);
      run_cfg(mk(63, 0, 63), 130);
      run_cfg(mk(63, 62, 63), 130);

      // R2: zero divider
      req = "R2";
      run_cfg(mk(0, 0, 0), 9);
      run_cfg(mk(0, 5, 0), 9);

      // R3: oversized high counts
      req = "R3";
      run_cfg(mk(5, 9, 5), 20);
      run_cfg(mk(1, 63, 1), 10);
      run_cfg(mk(63, 63, 63), 130);

      // R7: unused bits all ones, including source bit and third count
      req = "R7";
      run_cfg(32'hFFFC_0000 | mk(4, 1, 63), 20);
      run_cfg(32'h8000_0000 | mk(6, 2, 0), 22);
      run_cfg(32'hFFFC_0000 | mk(2, 0, 17), 12);

      // R6: change mid-period, then exactly on a wrap cycle
      req = "R6";
      cfg = mk(7, 3, 7);
      en  = 1'b1;
      repeat (10) step();
      cfg = mk(3, 0, 3);
      repeat (14) step();
      while (!(m_run && m_cnt == m_term)) step();
      cfg = mk(9, 6, 9);
      repeat (25) step();
      cfg = mk(2, 1, 2);
      repeat (3) step();
      cfg = mk(5, 2, 5);
      repeat (15) step();
      en = 1'b0;
      repeat (3) step();

      // R4: drop enable in the high phase and in the low phase, restart
      req = "R4";
      cfg = mk(8, 4, 8);
      en  = 1'b1;
      repeat (3) step();
      en = 1'b0;
      step();
      en = 1'b1;
      repeat (12) step();
      en = 1'b0;
      repeat (2) step();
      chk(req, "sck idle", int'(sck), 0);
      en = 1'b1;
      repeat (7) step();
      en = 1'b0;
      repeat (4) step();
      en = 1'b1;
      repeat (20) step();
      en = 1'b0;
      repeat (4) step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule